// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is an up-counting timer peripheral with a small word-indexed register bus. One of eight tick-enable inputs is chosen by a 3-bit source field. A 12-bit divider then passes one of every (divisor + 1) selected ticks to the counter. The counter is normally 32 bits wide. Three compare channels and a rollover detector set sticky status flags. Software clears a flag by writing 1 to its bit. A single level interrupt is raised when an enabled flag is pending and the timer is enabled.

The counter has two counting modes. In free-run mode it counts up to its all-ones value and wraps to zero. In restart mode a match on compare channel 1 sends it back to zero on the next advance, which gives a programmable period. Writing compare register 1 in restart mode also zeroes the counter. A control write with the reset-request bit set runs a soft reset, which keeps the enable, source and low-power control bits. Setting the enable bit while the restart-on-enable option is set zeroes both the counter and the divider.

Top module: `cmp_timer`

## Requirements
- R1: After the reset input is released, control, divisor, status and interrupt enable read 0, all three compare registers read all ones, the counter reads 0 and `irq` is low.
- R2: `bus_word` selects the register: 0 control, 1 divisor, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture (these read 0), 9 counter (read-only). Writes to indices 7, 8, 9 and 10–15 change nothing, and indices 10–15 read 0.
- R3: The counter advances by one on every (divisor + 1)-th selected tick. A divisor write keeps only bits [11:0].
- R4: Control bits [8:6] select the tick input `tick_src[sel]`. A value of 0 selects no input, and the counter holds.
- R5: In free-run mode (control bit 9 = 1) the counter wraps from all ones to 0. Each such wrap sets status bit 5 if interrupt-enable bit 5 is set.
- R6: In restart mode (control bit 9 = 0), an advance while the counter equals compare 1 loads 0.
- R7: A counter advance onto the value of compare channel k sets status bit k-1 (channels 1, 2, 3 use bits 0, 1, 2) if enable bit k-1 is set.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A hardware set in the same cycle as a clear wins. Interrupt-enable writes keep bits [5:0].
- R9: `irq` is high exactly when control bit 0 (enable) is 1 and (status AND interrupt enable) is nonzero.
- R10: A control write stores the value with bits 14:10, 4 and 2 forced to 0.
- R11: A control write with bit 15 set runs a soft reset. It zeroes the counter, divisor, status and interrupt enable, sets the compare registers to all ones, and keeps only control bits [8:0] of the written value. Bit 15 reads back 0.
- R12: A control write that takes bit 0 from 0 to 1 while bit 1 is set zeroes the counter and divider. With bit 0 low the counter holds its value, and it resumes from that value when re-enabled without bit 1.
- R13: Writing compare 1 in restart mode zeroes the counter. Writes to compare 2 and 3 never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_src | input | 8 | Tick-enable inputs, one per source code |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 4 | Register word index (address bits 5:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the selected register |
| irq | output | 1 | Level interrupt |

## Verification
A write takes effect at the clock edge that samples it, and a tick advances the counter and sets its flags at that same edge. Read data and `irq` come straight from the registers, so they are valid in the next low clock phase. The monitor pops one expected item at the falling edge inside each read or interrupt probe, one edge after the last stimulus that could affect it. Ticks are driven for an exact number of edges while the bus is idle, so every expected counter value is a plain count.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    // control bit positions
    localparam int CTL_EN    = 0;
    localparam int CTL_ENMOD = 1;
    localparam int CTL_DBG   = 2;
    localparam int CTL_WAIT  = 3;
    localparam int CTL_DOZE  = 4;
    localparam int CTL_STOP  = 5;
    localparam int CTL_SRC   = 6;
    localparam int SRC_W     = 3;
    localparam int CTL_FRR   = 9;
    localparam int CTL_SWR   = 15;

    localparam logic [31:0] CTL_WMASK = ~32'h0000_7C14;
    localparam logic [31:0] CTL_KEEP  = (32'd1 << CTL_EN) | (32'd1 << CTL_ENMOD) |
                                        (32'd1 << CTL_DBG) | (32'd1 << CTL_WAIT) |
                                        (32'd1 << CTL_DOZE) | (32'd1 << CTL_STOP) |
                                        (32'd7 << CTL_SRC);

    // status / enable flag positions
    localparam int FLAG_W  = 6;
    localparam int FLG_ROV = 5;

    typedef enum logic [3:0] {
        IDX_CTL  = 4'd0,
        IDX_DIV  = 4'd1,
        IDX_STS  = 4'd2,
        IDX_IEN  = 4'd3,
        IDX_CMP1 = 4'd4,
        IDX_CMP2 = 4'd5,
        IDX_CMP3 = 4'd6,
        IDX_CAP1 = 4'd7,
        IDX_CAP2 = 4'd8,
        IDX_CNT  = 4'd9
    } reg_idx_e;
endpackage

// File: rtl/cmp_timer_div.sv
module cmp_timer_div #(
    parameter int DIV_W = 12,
    parameter int SRC_W = 3,
    localparam int NSRC = 1 << SRC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  tick_src,
    input  logic [SRC_W-1:0] src_sel,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             clr,
    output logic             adv
);
    logic [DIV_W-1:0] pre_d, pre_q;
    logic             tick;

    always_comb begin
        tick  = (src_sel != '0) && tick_src[src_sel];
        pre_d = pre_q;
        adv   = 1'b0;
        if (clr) begin
            pre_d = '0;
        end else if (run && tick) begin
            if (pre_q >= div) begin
                pre_d = '0;
                adv   = 1'b1;
            end else begin
                pre_d = pre_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/cmp_timer_cmp.sv
module cmp_timer_cmp #(
    parameter int CNT_W = 32,
    parameter int NCH   = 3
) (
    input  logic [CNT_W-1:0]          cnt_nx,
    input  logic                      step,
    input  logic [NCH-1:0][CNT_W-1:0] cmp,
    input  logic [NCH-1:0]            ena,
    output logic [NCH-1:0]            hit
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign hit[c] = step && ena[c] && (cnt_nx == cmp[c]);
    end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 12,
    localparam int NCH  = 3,
    localparam int NSRC = 1 << SRC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] tick_src,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [3:0]      bus_word,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            irq
);
    typedef struct packed {
        logic [31:0]               ctl;
        logic [DIV_W-1:0]          div;
        logic [FLAG_W-1:0]         sts;
        logic [FLAG_W-1:0]         ien;
        logic [NCH-1:0][CNT_W-1:0] cmp;
        logic [CNT_W-1:0]          cnt;
    } regs_t;

    regs_t st_d, st_q;

    logic             wr, soft_rst, en_restart, pre_clr, adv;
    logic [31:0]      ctl_wv;
    logic [CNT_W-1:0] cnt_nx;
    logic [NCH-1:0]   hit;
    logic             rov_evt, frr;

    assign wr         = bus_sel && bus_we;
    assign ctl_wv     = bus_wdata & CTL_WMASK;
    assign soft_rst   = wr && (bus_word == IDX_CTL) && ctl_wv[CTL_SWR];
    assign en_restart = wr && (bus_word == IDX_CTL) && ctl_wv[CTL_EN] &&
                        !st_q.ctl[CTL_EN] && ctl_wv[CTL_ENMOD];
    assign pre_clr    = soft_rst || en_restart;
    assign frr        = st_q.ctl[CTL_FRR];

    cmp_timer_div #(.DIV_W(DIV_W), .SRC_W(SRC_W)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_src (tick_src),
        .src_sel  (st_q.ctl[CTL_SRC +: SRC_W]),
        .run      (st_q.ctl[CTL_EN]),
        .div      (st_q.div),
        .clr      (pre_clr),
        .adv      (adv)
    );

    assign cnt_nx = (!frr && st_q.cnt == st_q.cmp[0]) ? '0 : st_q.cnt + 1'b1;

    cmp_timer_cmp #(.CNT_W(CNT_W), .NCH(NCH)) cmp_i (
        .cnt_nx (cnt_nx),
        .step   (adv),
        .cmp    (st_q.cmp),
        .ena    (st_q.ien[NCH-1:0]),
        .hit    (hit)
    );

    assign rov_evt = adv && (st_q.cnt == '1) && st_q.ien[FLG_ROV];

    always_comb begin
        logic [FLAG_W-1:0] set_v, clr_v;
        st_d  = st_q;
        set_v = '0;
        set_v[NCH-1:0] = hit;
        set_v[FLG_ROV] = rov_evt;
        clr_v = (wr && bus_word == IDX_STS) ? bus_wdata[FLAG_W-1:0] : '0;
        st_d.sts = (st_q.sts & ~clr_v) | set_v;
        if (adv) st_d.cnt = cnt_nx;
        if (wr) begin
            case (bus_word)
                IDX_CTL: begin
                    if (ctl_wv[CTL_SWR]) begin
                        st_d.ctl = ctl_wv & CTL_KEEP;
                        st_d.div = '0;
                        st_d.sts = '0;
                        st_d.ien = '0;
                        st_d.cmp = '1;
                        st_d.cnt = '0;
                    end else begin
                        st_d.ctl = ctl_wv;
                        if (en_restart) st_d.cnt = '0;
                    end
                end
                IDX_DIV:  st_d.div = bus_wdata[DIV_W-1:0];
                IDX_IEN:  st_d.ien = bus_wdata[FLAG_W-1:0];
                IDX_CMP1: begin
                    st_d.cmp[0] = bus_wdata[CNT_W-1:0];
                    if (!frr) st_d.cnt = '0;
                end
                IDX_CMP2: st_d.cmp[1] = bus_wdata[CNT_W-1:0];
                IDX_CMP3: st_d.cmp[2] = bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cmp <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_word)
            IDX_CTL:  bus_rdata = st_q.ctl;
            IDX_DIV:  bus_rdata = 32'(st_q.div);
            IDX_STS:  bus_rdata = 32'(st_q.sts);
            IDX_IEN:  bus_rdata = 32'(st_q.ien);
            IDX_CMP1: bus_rdata = 32'(st_q.cmp[0]);
            IDX_CMP2: bus_rdata = 32'(st_q.cmp[1]);
            IDX_CMP3: bus_rdata = 32'(st_q.cmp[2]);
            IDX_CNT:  bus_rdata = 32'(st_q.cnt);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = st_q.ctl[CTL_EN] && (|(st_q.sts & st_q.ien));

    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr && frr) |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1))); // R3
    AST_SRC0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl[CTL_SRC +: SRC_W] == '0 && !wr) |=> $stable(st_q.cnt)); // R4
    AST_ROV_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr && st_q.cnt == '1 && st_q.ien[FLG_ROV]) |=> st_q.sts[FLG_ROV]); // R5
    AST_RESTART_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr && !frr && st_q.cnt == st_q.cmp[0]) |=> (st_q.cnt == '0)); // R6
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctl[CTL_EN] && !wr) |=> $stable(st_q.cnt)); // R12
endmodule

// File: tb/cmp_timer_tb_top.sv
module cmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tsrc = '0;
    logic        sel = 1'b0, we = 1'b0;
    logic [3:0]  word = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit probe = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    cmp_timer #(.CNT_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_src(tsrc),
        .bus_sel(sel), .bus_we(we), .bus_word(word),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    // monitor
    always @(negedge clk) begin
        if (probe && sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {31'd0, irq} : rdata;
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] idx, input logic [31:0] v);
        @(posedge clk); #1 sel = 1; we = 1; word = idx; wdata = v;
        @(posedge clk); #1 sel = 0; we = 0;
    endtask

    task automatic wr_tick(input logic [3:0] idx, input logic [31:0] v, input int b);
        @(posedge clk); #1 sel = 1; we = 1; word = idx; wdata = v; tsrc[b] = 1;
        @(posedge clk); #1 sel = 0; we = 0; tsrc[b] = 0;
    endtask

    task automatic rd(input logic [3:0] idx, input logic [31:0] e, input string tag);
        @(posedge clk); #1 sel = 1; we = 0; word = idx;
        sb.push_back('{is_irq: 1'b0, exp: e, tag: tag}); probe = 1;
        @(posedge clk); #1 sel = 0; probe = 0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(posedge clk); #1
        sb.push_back('{is_irq: 1'b1, exp: {31'd0, e}, tag: tag}); probe = 1;
        @(posedge clk); #1 probe = 0;
    endtask

    task automatic ticks(input int b, input int n);
        @(posedge clk); #1 tsrc[b] = 1;
        repeat (n) @(posedge clk);
        #1 tsrc[b] = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd(0, 32'h0, "R1 ctl");
        rd(1, 32'h0, "R1 div");
        rd(2, 32'h0, "R1 sts");
        rd(3, 32'h0, "R1 ien");
        rd(4, 32'hFF, "R1 cmp1");
        rd(5, 32'hFF, "R1 cmp2");
        rd(6, 32'hFF, "R1 cmp3");
        rd(9, 32'h0, "R1 cnt");
        chk_irq(0, "R1 irq");
        // R10 control mask; free-run, source 2, enabled
        wr(0, 32'h7E95);
        rd(0, 32'h281, "R10 ctl mask");
        // R3 divisor
        wr(1, 32'hFFFF_F003);
        rd(1, 32'h3, "R3 div width");
        ticks(2, 8);
        rd(9, 32'd2, "R3 divide by 4");
        wr(1, 32'h0);
        ticks(2, 3);
        rd(9, 32'd5, "R3 divide by 1");
        // R4 source select
        wr(0, 32'h341);
        ticks(2, 4);
        rd(9, 32'd5, "R4 unselected source");
        wr(0, 32'h201);
        ticks(0, 4);
        rd(9, 32'd5, "R4 source code 0");
        wr(0, 32'h341);
        ticks(5, 4);
        rd(9, 32'd9, "R4 source 5");
        // R7 compare flags, R8 enable mask
        wr(3, 32'hFFFF_FFFF);
        rd(3, 32'h3F, "R8 ien width");
        wr(4, 32'd15);
        wr(5, 32'd12);
        wr(6, 32'd20);
        rd(9, 32'd9, "R13 free-run cmp write");
        ticks(5, 3);
        rd(2, 32'h02, "R7 cmp2 flag");
        chk_irq(1, "R9 irq on flag");
        wr(2, 32'h02);
        rd(2, 32'h00, "R8 w1c");
        chk_irq(0, "R9 irq after clear");
        ticks(5, 8);
        rd(2, 32'h05, "R7 cmp1 and cmp3 flags");
        // R12 freeze, R9 gating
        wr(0, 32'h340);
        chk_irq(0, "R9 irq gated by enable");
        ticks(5, 3);
        rd(9, 32'd20, "R12 frozen");
        wr(0, 32'h341);
        chk_irq(1, "R9 irq re-enabled");
        rd(9, 32'd20, "R12 resume no restart");
        wr(2, 32'h3F);
        rd(2, 32'h00, "R8 clear all");
        // R5 rollover
        ticks(5, 235);
        rd(9, 32'd255, "R5 at max");
        ticks(5, 1);
        rd(9, 32'd0, "R5 wrap");
        rd(2, 32'h20, "R5 rov flag");
        wr(2, 32'h20);
        // restart mode
        wr(0, 32'h141);
        ticks(5, 3);
        wr(4, 32'd6);
        rd(9, 32'd0, "R13 cmp1 write zeroes");
        ticks(5, 2);
        wr(5, 32'd40);
        rd(9, 32'd2, "R13 cmp2 write keeps");
        wr(6, 32'd50);
        rd(9, 32'd2, "R13 cmp3 write keeps");
        ticks(5, 5);
        rd(9, 32'd0, "R6 restart wrap");
        rd(2, 32'h01, "R6 cmp1 flag");
        // R8 set wins over clear
        ticks(5, 5);
        wr_tick(2, 32'h01, 5);
        rd(9, 32'd6, "R8 tick with clear");
        rd(2, 32'h01, "R8 set wins");
        // R12 restart on enable
        wr(0, 32'h140);
        rd(9, 32'd6, "R12 disabled");
        wr(0, 32'h143);
        rd(9, 32'd0, "R12 enable restart");
        // R11 soft reset
        wr(1, 32'd7);
        ticks(5, 16);
        rd(9, 32'd2, "R3 divide by 8");
        wr(0, 32'h83FF);
        rd(0, 32'h1EB, "R11 ctl kept");
        rd(1, 32'h0, "R11 div");
        rd(2, 32'h0, "R11 sts");
        rd(3, 32'h0, "R11 ien");
        rd(4, 32'hFF, "R11 cmp1");
        rd(5, 32'hFF, "R11 cmp2");
        rd(6, 32'hFF, "R11 cmp3");
        rd(9, 32'h0, "R11 cnt");
        chk_irq(0, "R11 irq");
        // R2 map edges
        wr(4'd10, 32'h55);
        wr(4'd9, 32'h77);
        wr(4'd7, 32'h12);
        wr(4'd15, 32'hFFFF_FFFF);
        rd(9, 32'h0, "R2 cnt read-only");
        rd(4'd10, 32'h0, "R2 unmapped read");
        rd(7, 32'h0, "R2 cap1");
        rd(8, 32'h0, "R2 cap2");
        rd(0, 32'h1EB, "R2 ctl untouched");
        rd(1, 32'h0, "R2 div untouched");
        rd(3, 32'h0, "R2 ien untouched");
        rd(4, 32'hFF, "R2 cmp1 untouched");
        repeat (2) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule